// File: doc/BRIEF.md
# Page Lock Tracker for Concurrent Privileged Page Operations

This block keeps a small table of page locks for privileged page operations that several threads can issue at once. Each locking request names two pages. The target page is the one the operation writes, and the tracker must own it alone. The control page is the one the operation depends on, and other requests may hold it at the same time. The tracker checks the target first and then the control page. It either takes both holds in one step or takes neither and reports a conflict. The caller turns a conflict into a general-protection fault at once and does not wait.

Some operation classes never conflict with a locking operation: accept, permission-modify, type-modify, build-time and tracking operations. For these classes the tracker grants the request and leaves the table unchanged. A thread that holds locks frees them by sending a release that names the same two pages.

Requests arrive on one valid/ready channel per thread. A requester holds `req_valid` and its fields steady until it sees `req_ready`. The request transfers in the cycle where both are high. At most one `req_ready` is high in a cycle. It goes to the lowest-numbered valid thread, and it is forced low in any cycle where a release is presented. `req_ready` depends on `req_valid` within the same cycle. The response has no back-pressure: it is a one-cycle pulse.

Top module: `plt_tracker`

## Requirements
- R1: After reset the table is empty, `req_ready` and `resp_valid` are low, and the first locking request on any two distinct pages is granted.
- R2: A locking request (class code 0, 6 or 7) whose target page is already held in any mode is answered with conflict. A granted request holds its target page exclusively.
- R3: The control page is taken shared. It conflicts only when the page is held exclusively, and any number of shared holders up to the count limit may hold it together.
- R4: The target is checked before the control page. When the control check fails, nothing is held afterwards. A request whose target page equals its control page is a conflict.
- R5: Requests with class codes 1 to 5 are always granted and leave the table unchanged. The codes are 1 accept, 2 permission-modify, 3 type-modify, 4 build-time and 5 tracking.
- R6: A request that needs more free entries than remain is a conflict. A new target takes one entry, and a control page not yet held takes a second.
- R7: When several threads request at once, only the lowest thread ID sees `req_ready`. The others keep waiting.
- R8: A release takes effect only when its thread owns an exclusive entry for the released target page. It then frees that entry and decrements the shared count of the released control page, freeing that entry at zero. Any other release is ignored.
- R9: In a cycle with `rel_valid` high, no request is accepted.
- R10: One cycle after a handshake, `resp_valid` pulses with the accepted `resp_tid`, and exactly one of `resp_grant` and `resp_conflict` is high.
- R11: Pages are 4 KiB. Address bits [11:0] play no part in matching.
- R12: A control page whose shared count is at 2^CNT_W-1 refuses a further shared holder with conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_THREADS | Request valid, one bit per thread |
| req_ready | output | NUM_THREADS | Request accepted, one-hot or zero |
| req_tgt_addr | input | NUM_THREADS*ADDR_W | Target page address per thread |
| req_ctl_addr | input | NUM_THREADS*ADDR_W | Control page address per thread |
| req_class | input | NUM_THREADS*3 | Operation class per thread |
| rel_valid | input | 1 | Release strobe |
| rel_tid | input | TID_W | Releasing thread |
| rel_tgt_addr | input | ADDR_W | Target page being released |
| rel_ctl_addr | input | ADDR_W | Control page being released |
| resp_valid | output | 1 | Response pulse |
| resp_tid | output | TID_W | Thread the response belongs to |
| resp_grant | output | 1 | Both holds taken, or exempt class |
| resp_conflict | output | 1 | Request refused; caller raises a fault |

## Verification
The assertions rely on three things about the inputs. Every requester keeps `req_valid` and its fields steady until it is accepted. A release names pages its thread is meant to hold. Nothing but the tracker changes the table. The bench drives one transaction at a time from tasks that hold each request until its ready and drop it on the following falling edge. Releases come in separate cycles, except in the one test where a release deliberately overlaps a pending request. The random sweep draws its pages from a small pool, so the table fills, pages are shared and ownership collides often. A reference model written from the requirements predicts every response.

// File: rtl/plt_pkg.sv
package plt_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int CLASS_W    = 3;

  typedef enum logic [CLASS_W-1:0] {
    OPC_LOCKING  = 3'd0,
    OPC_ACCEPT   = 3'd1,
    OPC_PERM_MOD = 3'd2,
    OPC_TYPE_MOD = 3'd3,
    OPC_BUILD    = 3'd4,
    OPC_TRACK    = 3'd5,
    OPC_RSVD6    = 3'd6,
    OPC_RSVD7    = 3'd7
  } op_class_e;

  // classes that run alongside a locking operation without touching the table
  function automatic logic class_exempt(input logic [CLASS_W-1:0] c);
    return (c >= OPC_ACCEPT) && (c <= OPC_TRACK);
  endfunction
endpackage

// File: rtl/plt_arb.sv
module plt_arb #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_prio
    assign seen[i+1] = seen[i] | req[i];
    assign gnt[i]    = req[i] & ~seen[i];
  end
  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (gnt[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/plt_cam.sv
module plt_cam #(
  parameter int NE = 8,
  parameter int TW = 20
) (
  input  logic [NE-1:0]    valid,
  input  logic [NE*TW-1:0] tags,
  input  logic [TW-1:0]    key,
  output logic [NE-1:0]    hit
);
  for (genvar i = 0; i < NE; i++) begin : g_cmp
    assign hit[i] = valid[i] && (tags[i*TW +: TW] == key);
  end
endmodule

// File: rtl/plt_free.sv
module plt_free #(
  parameter int NE = 8,
  parameter int IW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic [NE-1:0] used,
  output logic [IW-1:0] first_idx,
  output logic [IW-1:0] second_idx,
  output logic          have_first,
  output logic          have_second
);
  always_comb begin
    int n;
    n          = 0;
    first_idx  = '0;
    second_idx = '0;
    for (int i = 0; i < NE; i++) begin
      if (!used[i]) begin
        if (n == 0) first_idx = IW'(i);
        else if (n == 1) second_idx = IW'(i);
        if (n < 2) n = n + 1;
      end
    end
    have_first  = (n >= 1);
    have_second = (n >= 2);
  end
endmodule

// File: rtl/plt_tracker.sv
module plt_tracker
  import plt_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 3,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_THREADS-1:0]        req_valid,
  output logic [NUM_THREADS-1:0]        req_ready,
  input  logic [NUM_THREADS*ADDR_W-1:0] req_tgt_addr,
  input  logic [NUM_THREADS*ADDR_W-1:0] req_ctl_addr,
  input  logic [NUM_THREADS*3-1:0]      req_class,
  input  logic                          rel_valid,
  input  logic [TID_W-1:0]              rel_tid,
  input  logic [ADDR_W-1:0]             rel_tgt_addr,
  input  logic [ADDR_W-1:0]             rel_ctl_addr,
  output logic                          resp_valid,
  output logic [TID_W-1:0]              resp_tid,
  output logic                          resp_grant,
  output logic                          resp_conflict
);
  localparam int NE    = NUM_ENTRIES;
  localparam int IDX_W = (NE > 1) ? $clog2(NE) : 1;
  localparam int TAG_W = ADDR_W - PAGE_SHIFT;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // ---------------- lock table storage ----------------
  logic [NE-1:0]    ent_v;
  logic [NE-1:0]    ent_x;
  logic [TAG_W-1:0] ent_tag [NE];
  logic [CNT_W-1:0] ent_cnt [NE];
  logic [TID_W-1:0] ent_own [NE];
  logic [NE*TAG_W-1:0] tag_flat;
  logic [NE-1:0]    own_match;

  for (genvar i = 0; i < NE; i++) begin : g_flat
    assign tag_flat[i*TAG_W +: TAG_W] = ent_tag[i];
    assign own_match[i]               = (ent_own[i] == rel_tid);
  end

  function automatic logic [IDX_W-1:0] enc_idx(input logic [NE-1:0] v);
    enc_idx = '0;
    for (int i = 0; i < NE; i++) begin
      if (v[i]) enc_idx = IDX_W'(i);
    end
  endfunction

  // ---------------- request arbitration ----------------
  logic [NUM_THREADS-1:0] arb_req;
  logic [TID_W-1:0]       sel_tid;
  logic                   acc;

  assign arb_req = req_valid & {NUM_THREADS{~rel_valid}};

  plt_arb #(.N(NUM_THREADS), .IW(TID_W)) u_arb (
    .req (arb_req),
    .gnt (req_ready),
    .idx (sel_tid),
    .any (acc)
  );

  logic [TAG_W-1:0]   sel_tgt_tag;
  logic [TAG_W-1:0]   sel_ctl_tag;
  logic [CLASS_W-1:0] sel_cls;

  assign sel_tgt_tag = req_tgt_addr[int'(sel_tid)*ADDR_W + PAGE_SHIFT +: TAG_W];
  assign sel_ctl_tag = req_ctl_addr[int'(sel_tid)*ADDR_W + PAGE_SHIFT +: TAG_W];
  assign sel_cls     = req_class[int'(sel_tid)*CLASS_W +: CLASS_W];

  // page offsets never take part in matching
  logic unused_offsets;
  assign unused_offsets = ^{req_tgt_addr, req_ctl_addr,
                            rel_tgt_addr[PAGE_SHIFT-1:0], rel_ctl_addr[PAGE_SHIFT-1:0]};

  // ---------------- lookups ----------------
  logic [NE-1:0] hit_t, hit_c, hit_rt, hit_rc;

  plt_cam #(.NE(NE), .TW(TAG_W)) u_cam_tgt (
    .valid(ent_v), .tags(tag_flat), .key(sel_tgt_tag), .hit(hit_t));
  plt_cam #(.NE(NE), .TW(TAG_W)) u_cam_ctl (
    .valid(ent_v), .tags(tag_flat), .key(sel_ctl_tag), .hit(hit_c));
  plt_cam #(.NE(NE), .TW(TAG_W)) u_cam_rel_tgt (
    .valid(ent_v), .tags(tag_flat), .key(rel_tgt_addr[ADDR_W-1:PAGE_SHIFT]), .hit(hit_rt));
  plt_cam #(.NE(NE), .TW(TAG_W)) u_cam_rel_ctl (
    .valid(ent_v), .tags(tag_flat), .key(rel_ctl_addr[ADDR_W-1:PAGE_SHIFT]), .hit(hit_rc));

  logic [IDX_W-1:0] f0_idx, f1_idx;
  logic             have_f0, have_f1;

  plt_free #(.NE(NE), .IW(IDX_W)) u_free (
    .used        (ent_v),
    .first_idx   (f0_idx),
    .second_idx  (f1_idx),
    .have_first  (have_f0),
    .have_second (have_f1)
  );

  // ---------------- stage 1: target page, exclusive ----------------
  logic tgt_busy, tgt_ok, tgt_take;
  logic exempt;

  assign exempt   = class_exempt(sel_cls);
  assign tgt_busy = |hit_t;
  assign tgt_ok   = !tgt_busy && have_f0;
  assign tgt_take = acc && !exempt && tgt_ok;

  // ---------------- stage 2: control page, shared ----------------
  logic [NE-1:0]    sh_vec;
  logic [IDX_W-1:0] sh_idx;
  logic             ctl_excl, ctl_sh, sh_full, same_pg, ctl_ok;
  logic             tgt_undo, tgt_commit, grant_c;

  assign sh_vec   = hit_c & ~ent_x;
  assign sh_idx   = enc_idx(sh_vec);
  assign ctl_sh   = |sh_vec;
  assign ctl_excl = |(hit_c & ent_x);
  assign sh_full  = (ent_cnt[sh_idx] == CNT_MAX);
  assign same_pg  = (sel_tgt_tag == sel_ctl_tag);
  assign ctl_ok   = tgt_ok && !same_pg && !ctl_excl && (ctl_sh ? !sh_full : have_f1);

  // a target hold won in stage 1 is dropped in the same cycle when stage 2 fails
  assign tgt_undo   = tgt_take && !ctl_ok;
  assign tgt_commit = tgt_take && !tgt_undo;
  assign grant_c    = exempt || ctl_ok;

  // ---------------- release decode ----------------
  logic [NE-1:0]    rx_vec, rc_vec;
  logic [IDX_W-1:0] rx_idx, rc_idx;
  logic             rel_do, rc_hit;

  assign rx_vec = hit_rt & ent_x & own_match;
  assign rx_idx = enc_idx(rx_vec);
  assign rel_do = rel_valid && (|rx_vec);
  assign rc_vec = hit_rc & ~ent_x;
  assign rc_idx = enc_idx(rc_vec);
  assign rc_hit = |rc_vec;

  // ---------------- state update ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v         <= '0;
      ent_x         <= '0;
      for (int i = 0; i < NE; i++) begin
        ent_tag[i] <= '0;
        ent_cnt[i] <= '0;
        ent_own[i] <= '0;
      end
      resp_valid    <= 1'b0;
      resp_tid      <= '0;
      resp_grant    <= 1'b0;
      resp_conflict <= 1'b0;
    end else begin
      resp_valid    <= acc;
      resp_tid      <= sel_tid;
      resp_grant    <= acc && grant_c;
      resp_conflict <= acc && !grant_c;

      if (tgt_commit) begin
        ent_v[f0_idx]   <= 1'b1;
        ent_x[f0_idx]   <= 1'b1;
        ent_tag[f0_idx] <= sel_tgt_tag;
        ent_cnt[f0_idx] <= CNT_ONE;
        ent_own[f0_idx] <= sel_tid;
        if (ctl_sh) begin
          ent_cnt[sh_idx] <= ent_cnt[sh_idx] + CNT_ONE;
        end else begin
          ent_v[f1_idx]   <= 1'b1;
          ent_x[f1_idx]   <= 1'b0;
          ent_tag[f1_idx] <= sel_ctl_tag;
          ent_cnt[f1_idx] <= CNT_ONE;
          ent_own[f1_idx] <= sel_tid;
        end
      end

      if (rel_do) begin
        ent_v[rx_idx]   <= 1'b0;
        ent_x[rx_idx]   <= 1'b0;
        ent_cnt[rx_idx] <= '0;
        if (rc_hit) begin
          if (ent_cnt[rc_idx] == CNT_ONE) begin
            ent_v[rc_idx]   <= 1'b0;
            ent_cnt[rc_idx] <= '0;
          end else begin
            ent_cnt[rc_idx] <= ent_cnt[rc_idx] - CNT_ONE;
          end
        end
      end
    end
  end

  // ---------------- assertions ----------------
  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_t)); // R2

  AST_READY_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0); // R7

  AST_READY_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |-> (((req_ready - 1'b1) & req_valid) == '0)); // R7

  AST_RELEASE_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (req_ready == '0)); // R9

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> (resp_valid && (resp_grant != resp_conflict))); // R10

  AST_RESP_ONLY_AFTER_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> (!resp_grant && !resp_conflict)); // R10

  AST_NO_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_conflict) |-> (ent_v == $past(ent_v))); // R4

  AST_EXEMPT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && exempt) |=> (ent_v == $past(ent_v))); // R5

  for (genvar i = 0; i < NE; i++) begin : g_ent_chk
    AST_EXCL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_v[i] && ent_x[i]) |-> (ent_cnt[i] == CNT_ONE)); // R2
    AST_SHARE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_v[i] && !ent_x[i]) |-> (ent_cnt[i] != '0)); // R8
  end
endmodule

// File: tb/plt_tracker_test.sv
`timescale 1ns/1ps
module plt_tracker_test;
  localparam int NT = 4;
  localparam int NE = 4;
  localparam int AW = 32;
  localparam int CW = 2;
  localparam int CMAX = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NT-1:0]   req_valid = '0;
  logic [NT-1:0]   req_ready;
  logic [NT*AW-1:0] req_tgt_addr = '0;
  logic [NT*AW-1:0] req_ctl_addr = '0;
  logic [NT*3-1:0] req_class = '0;
  logic            rel_valid = 1'b0;
  logic [1:0]      rel_tid = '0;
  logic [AW-1:0]   rel_tgt_addr = '0;
  logic [AW-1:0]   rel_ctl_addr = '0;
  logic            resp_valid;
  logic [1:0]      resp_tid;
  logic            resp_grant;
  logic            resp_conflict;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  plt_tracker #(.NUM_THREADS(NT), .NUM_ENTRIES(NE), .ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_tgt_addr(req_tgt_addr), .req_ctl_addr(req_ctl_addr), .req_class(req_class),
    .rel_valid(rel_valid), .rel_tid(rel_tid),
    .rel_tgt_addr(rel_tgt_addr), .rel_ctl_addr(rel_ctl_addr),
    .resp_valid(resp_valid), .resp_tid(resp_tid),
    .resp_grant(resp_grant), .resp_conflict(resp_conflict)
  );

  // ---------------- reference model of the table ----------------
  bit mv [NE];
  bit mex[NE];
  int mtag[NE];
  int mcnt[NE];
  int mown[NE];

  task automatic model_clear();
    for (int i = 0; i < NE; i++) begin
      mv[i] = 0; mex[i] = 0; mtag[i] = 0; mcnt[i] = 0; mown[i] = 0;
    end
  endtask

  task automatic model_alloc(input int tag, input bit ex, input int own);
    for (int i = 0; i < NE; i++) begin
      if (!mv[i]) begin
        mv[i] = 1; mex[i] = ex; mtag[i] = tag; mcnt[i] = 1; mown[i] = own;
        return;
      end
    end
  endtask

  task automatic model_req(input int tid, input int tp, input int cp, input int cls,
                           output bit g, output string lab);
    int fc;
    int ci;
    g = 0;
    if (cls >= 1 && cls <= 5) begin g = 1; lab = "R5"; return; end
    for (int i = 0; i < NE; i++)
      if (mv[i] && mtag[i] == tp) begin lab = "R2"; return; end
    fc = 0;
    for (int i = 0; i < NE; i++) if (!mv[i]) fc++;
    if (fc == 0) begin lab = "R6"; return; end
    if (tp == cp) begin lab = "R4"; return; end
    ci = -1;
    for (int i = 0; i < NE; i++) if (mv[i] && mtag[i] == cp) ci = i;
    if (ci >= 0 && mex[ci]) begin lab = "R3"; return; end
    if (ci >= 0 && mcnt[ci] == CMAX) begin lab = "R12"; return; end
    if (ci < 0 && fc < 2) begin lab = "R6"; return; end
    g = 1;
    model_alloc(tp, 1, tid);
    if (ci >= 0) begin mcnt[ci]++; lab = "R3"; end
    else begin model_alloc(cp, 0, tid); lab = "R2"; end
  endtask

  task automatic model_rel(input int tid, input int tp, input int cp);
    int xi;
    xi = -1;
    for (int i = 0; i < NE; i++)
      if (mv[i] && mex[i] && mtag[i] == tp && mown[i] == tid) xi = i;
    if (xi < 0) return;
    mv[xi] = 0; mex[xi] = 0;
    for (int i = 0; i < NE; i++) begin
      if (mv[i] && !mex[i] && mtag[i] == cp) begin
        mcnt[i]--;
        if (mcnt[i] == 0) mv[i] = 0;
      end
    end
  endtask

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] pg(input int p, input int off);
    return AW'((p << 12) | (off & 32'hfff));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = '0; rel_valid = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(req_ready == '0, "R1", "ready after reset", req_ready, 0);
    chk(resp_valid == 0, "R1", "resp_valid after reset", resp_valid, 0);
  endtask

  task automatic set_req(input int tid, input int tp, input int toff,
                         input int cp, input int coff, input int cls);
    req_tgt_addr[tid*AW +: AW] = pg(tp, toff);
    req_ctl_addr[tid*AW +: AW] = pg(cp, coff);
    req_class[tid*3 +: 3]      = 3'(cls);
  endtask

  task automatic check_resp(input int tid, input bit g, input string lab, input string note);
    chk(resp_valid == 1 && resp_tid == 2'(tid), "R10", {note, " resp tid"}, resp_tid, tid);
    chk(resp_grant == g && resp_conflict == !g, lab, {note, " grant"}, {resp_grant, resp_conflict},
        {g, !g});
  endtask

  task automatic do_req(input int tid, input int tp, input int toff, input int cp,
                        input int coff, input int cls, input string note);
    bit g;
    string lab;
    @(negedge clk);
    set_req(tid, tp, toff, cp, coff, cls);
    req_valid[tid] = 1'b1;
    #1;
    chk(req_ready == NT'(1 << tid), "R7", {note, " ready"}, req_ready, 1 << tid);
    model_req(tid, tp, cp, cls, g, lab);
    @(posedge clk);
    @(negedge clk);
    req_valid[tid] = 1'b0;
    check_resp(tid, g, lab, note);
  endtask

  task automatic do_rel(input int tid, input int tp, input int cp, input int off);
    @(negedge clk);
    rel_tid = 2'(tid); rel_tgt_addr = pg(tp, off); rel_ctl_addr = pg(cp, off);
    rel_valid = 1;
    model_rel(tid, tp, cp);
    @(posedge clk);
    @(negedge clk);
    rel_valid = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 150000, 0);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] lfsr;
    bit g;
    string lab;

    // R1, R2, R3, R4, R6, R8, R11 directed
    do_reset();
    do_req(0, 1, 0, 9, 0, 0, "R1 first lock");
    do_req(1, 1, 5, 8, 0, 0, "R2 target held");
    do_req(1, 2, 0, 9, 7, 0, "R3 shared control");
    do_req(2, 3, 0, 1, 0, 0, "R3 control held exclusive");
    do_req(3, 3, 0, 4, 0, 0, "R6 one free entry");
    do_req(3, 3, 0, 9, 0, 0, "R4 no partial hold kept");
    do_req(2, 5, 0, 9, 0, 0, "R6 table full");
    do_rel(2, 2, 9, 0);
    do_req(0, 2, 0, 9, 0, 0, "R8 non-owner release ignored");
    do_rel(1, 2, 9, 0);
    do_req(2, 2, 12'habc, 9, 12'h123, 0, "R11 offset ignored");
    do_req(0, 9, 0, 7, 0, 0, "R2 shared page as target");

    // R12 saturation, R4 same page
    do_reset();
    do_req(0, 1, 0, 6, 0, 0, "R12 fill");
    do_req(1, 2, 0, 6, 0, 0, "R12 fill");
    do_req(2, 3, 0, 6, 0, 0, "R12 fill");
    do_rel(2, 3, 7, 0);
    do_req(3, 4, 0, 6, 0, 0, "R12 count at limit");
    do_req(3, 4, 0, 4, 0, 0, "R4 target equals control");
    do_rel(0, 1, 6, 0);
    do_req(3, 4, 0, 6, 0, 0, "R8 count decremented");

    // R5 exempt classes leave table unchanged
    do_reset();
    do_req(0, 1, 0, 2, 0, 0, "R5 base");
    for (int c = 1; c <= 5; c++) do_req(1, 1, 0, 1, 0, c, "R5 exempt");
    do_req(1, 3, 0, 4, 0, 3, "R5 exempt new page");
    do_req(2, 3, 0, 4, 0, 0, "R5 page untouched");
    do_req(3, 5, 0, 6, 0, 6, "R2 reserved class locks");

    // R7 priority and R9 release hold-off
    do_reset();
    @(negedge clk);
    set_req(1, 1, 0, 9, 0, 0);
    set_req(2, 2, 0, 9, 0, 0);
    set_req(3, 3, 0, 9, 0, 0);
    req_valid = 4'b1110;
    #1;
    chk(req_ready == 4'b0010, "R7", "lowest of three", req_ready, 4'b0010);
    model_req(1, 1, 9, 0, g, lab);
    @(posedge clk); @(negedge clk);
    req_valid[1] = 0;
    check_resp(1, g, lab, "R7 first winner");
    #1;
    chk(req_ready == 4'b0100, "R7", "next waiter", req_ready, 4'b0100);
    model_req(2, 2, 9, 0, g, lab);
    @(posedge clk); @(negedge clk);
    req_valid[2] = 0;
    check_resp(2, g, lab, "R7 second winner");
    rel_tid = 2'd0; rel_tgt_addr = pg(15, 0); rel_ctl_addr = pg(15, 0); rel_valid = 1;
    #1;
    chk(req_ready == 4'b0000, "R9", "ready during release", req_ready, 0);
    @(posedge clk); @(negedge clk);
    chk(resp_valid == 0, "R9", "no response during release", resp_valid, 0);
    rel_valid = 0;
    #1;
    chk(req_ready == 4'b1000, "R7", "last waiter", req_ready, 4'b1000);
    model_req(3, 3, 9, 0, g, lab);
    @(posedge clk); @(negedge clk);
    req_valid[3] = 0;
    check_resp(3, g, lab, "R7 third winner");

    // near-exhaustive sweep over a small page pool
    lfsr = 32'h1ace_b00c;
    for (int n = 0; n < 4000; n++) begin
      int tid, tp, cp, off, cls;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (n % 250 == 0) do_reset();
      tid = int'(lfsr[1:0]);
      tp  = int'(lfsr[4:2]);
      cp  = int'(lfsr[7:5]);
      off = int'(lfsr[19:8]);
      cls = (lfsr[24:23] == 2'd0) ? int'(lfsr[22:20]) : 0;
      if (lfsr[27:25] < 3'd3) do_rel(tid, tp, cp, off);
      else do_req(tid, tp, off, cp, off ^ 12'h5a5, cls, "R3 sweep");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule